// File: doc/BRIEF.md
# Grid Local Maximum and Centroid Finder

This block receives the accumulated weight sums of a two-dimensional grid of pattern cells, once every hit of an event has been added in. It picks out the track candidates and streams them out. A cell is a candidate when two conditions hold. Its sum must exceed a programmable threshold. It must also be a local maximum among its eight neighbours. Each candidate carries its grid indices, its peak sum and a refined position. The refined position is the offset of the weighted centroid of its 3x3 neighbourhood, given as a signed fixed-point fraction of one cell pitch.

A `start` pulse while the block is idle captures the whole grid and the threshold. The block then visits the cells one per cycle in row-major order. It is built around four named states:

- `ST_IDLE` waits for `start`.
- `ST_SCAN` evaluates one cell per cycle.
- `ST_EMIT` offers a held candidate, knowing that another follows it.
- `ST_FLUSH` offers the final beat of the event, marked as last.

The transitions are:

- IDLE→SCAN on start.
- SCAN→EMIT when a new candidate is found while one is already held.
- SCAN→FLUSH after the last cell.
- EMIT→SCAN or EMIT→FLUSH when the beat is accepted.
- FLUSH→IDLE when the final beat is accepted.

Top module: `grid_peak_finder`

## Requirements
- R1: After reset, `busy` and `cand_valid` are low.
- R2: A `start` pulse seen while `busy` is low captures `grid_sums` and `threshold`. While `busy` is high, `start`, `grid_sums` and `threshold` have no effect on the event in progress.
- R3: A cell can be a candidate only if its sum is strictly greater than the captured threshold.
- R4: A candidate's sum is strictly greater than each of its up-left, up, up-right and left neighbours. It is also greater than or equal to each of its right, down-left, down and down-right neighbours. Neighbours outside the grid count as zero. A flat plateau therefore yields one candidate.
- R5: Cell (row r, column c) is taken from bits `[(r*COLS+c)*SUM_W +: SUM_W]` of `grid_sums`, with row 0 and column 0 at the top-left. Candidates leave in row-major order, with `cand_row` = r and `cand_col` = c.
- R6: `cand_dcol` equals (sum of the right column of the 3x3 window − sum of the left column) × 2^FRAC_W ÷ window total, truncated toward zero. `cand_drow` is the same with the lower row minus the upper row. Both are two's complement, FRAC_W+1 bits wide, and window cells outside the grid count as zero.
- R7: `cand_peak` equals the candidate cell's sum.
- R8: The last candidate of an event has `cand_last`=1. Every earlier candidate has `cand_last`=0. Real candidates have `cand_empty`=0.
- R9: An event with no candidate produces exactly one beat, with `cand_last`=1 and `cand_empty`=1.
- R10: While `cand_valid` is high and `cand_ready` is low, every candidate output holds its value. After the beat with `cand_last` is accepted, `busy` is low on the next cycle.
- R11: With `cand_ready` held high and no candidate in the grid, `busy` stays high for exactly ROWS*COLS+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an event; acted on only while idle |
| threshold | input | SUM_W | Minimum sum a candidate must exceed |
| grid_sums | input | ROWS*COLS*SUM_W | Cell sums, row-major |
| busy | output | 1 | Event in progress |
| cand_valid | output | 1 | Candidate beat offered |
| cand_ready | input | 1 | Consumer accepts the beat |
| cand_row | output | RW | Row index of the candidate |
| cand_col | output | CW | Column index of the candidate |
| cand_drow | output | FRAC_W+1 | Signed row offset of the centroid |
| cand_dcol | output | FRAC_W+1 | Signed column offset of the centroid |
| cand_peak | output | SUM_W | Sum at the candidate cell |
| cand_last | output | 1 | Final beat of the event |
| cand_empty | output | 1 | Beat carries no candidate |

## Verification
Two things can happen in the same cycle: the scan finds a new peak, and the consumer is still stalling the previous candidate. The scan must then freeze on that cell and not lose it. Random `cand_ready` duty cycles on grids dense with small values provoke this often. Each accepted stream is compared beat by beat against a list computed in the bench, so that no candidate is dropped or duplicated, and a stalled beat is checked to stay unchanged. A second collision is a `start` pulse with a different grid arriving mid-scan, which must leave the running event's stream untouched.

// File: rtl/grid_pf_pkg.sv
package grid_pf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_EMIT  = 2'd2,
        ST_FLUSH = 2'd3
    } pf_state_e;

    // 3x3 window: index = (drow+1)*3 + (dcol+1)
    localparam int WIN_CELLS  = 9;
    localparam int WIN_CENTRE = 4;
endpackage

// File: rtl/grid_window.sv
module grid_window #(
    parameter int ROWS  = 6,
    parameter int COLS  = 8,
    parameter int SUM_W = 8,
    parameter int RW    = 3,
    parameter int CW    = 3
) (
    input  logic [ROWS*COLS*SUM_W-1:0] grid_flat,
    input  logic [RW-1:0]              row,
    input  logic [CW-1:0]              col,
    output logic [9*SUM_W-1:0]         win_flat
);
    for (genvar gr = 0; gr < 3; gr++) begin : g_r
        for (genvar gc = 0; gc < 3; gc++) begin : g_c
            logic [SUM_W-1:0] val;
            always_comb begin
                int rr;
                int cc;
                rr = int'(row) + gr - 1;
                cc = int'(col) + gc - 1;
                if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS)
                    val = grid_flat[(rr*COLS+cc)*SUM_W +: SUM_W];
                else
                    val = '0;
            end
            assign win_flat[(gr*3+gc)*SUM_W +: SUM_W] = val;
        end
    end
endmodule

// File: rtl/peak_eval.sv
module peak_eval #(
    parameter int SUM_W = 8
) (
    input  logic [9*SUM_W-1:0] win_flat,
    input  logic [SUM_W-1:0]   thr,
    output logic               is_peak
);
    import grid_pf_pkg::*;

    always_comb begin
        logic [SUM_W-1:0] ctr;
        ctr = win_flat[WIN_CENTRE*SUM_W +: SUM_W];
        is_peak = (ctr > thr);
        for (int k = 0; k < WIN_CELLS; k++) begin
            if (k < WIN_CENTRE) begin
                // neighbours earlier in scan order: strict
                if (!(ctr > win_flat[k*SUM_W +: SUM_W])) is_peak = 1'b0;
            end else if (k > WIN_CENTRE) begin
                // neighbours later in scan order: ties allowed
                if (ctr < win_flat[k*SUM_W +: SUM_W]) is_peak = 1'b0;
            end
        end
    end
endmodule

// File: rtl/centroid_calc.sv
module centroid_calc #(
    parameter int SUM_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic [9*SUM_W-1:0]        win_flat,
    output logic signed [FRAC_W:0]    drow,
    output logic signed [FRAC_W:0]    dcol
);
    localparam int TW = SUM_W + 4;
    localparam int NW = TW + FRAC_W;

    function automatic logic [TW-1:0] cell_at(input logic [9*SUM_W-1:0] w, input int k);
        return TW'(w[k*SUM_W +: SUM_W]);
    endfunction

    function automatic logic signed [FRAC_W:0] offset(input logic [TW-1:0] pos,
                                                      input logic [TW-1:0] neg,
                                                      input logic [TW-1:0] tot);
        logic [NW-1:0] mag;
        logic [NW-1:0] quo;
        logic          minus;
        minus = (neg > pos);
        mag   = minus ? (NW'(neg - pos) << FRAC_W) : (NW'(pos - neg) << FRAC_W);
        quo   = (tot == '0) ? '0 : mag / NW'(tot);
        return minus ? -$signed((FRAC_W+1)'(quo)) : $signed((FRAC_W+1)'(quo));
    endfunction

    logic [TW-1:0] s_up, s_dn, s_lf, s_rt, s_all;

    always_comb begin
        s_up  = cell_at(win_flat, 0) + cell_at(win_flat, 1) + cell_at(win_flat, 2);
        s_dn  = cell_at(win_flat, 6) + cell_at(win_flat, 7) + cell_at(win_flat, 8);
        s_lf  = cell_at(win_flat, 0) + cell_at(win_flat, 3) + cell_at(win_flat, 6);
        s_rt  = cell_at(win_flat, 2) + cell_at(win_flat, 5) + cell_at(win_flat, 8);
        s_all = s_up + s_dn + cell_at(win_flat, 3) + cell_at(win_flat, 4) + cell_at(win_flat, 5);
        drow  = offset(s_dn, s_up, s_all);
        dcol  = offset(s_rt, s_lf, s_all);
    end
endmodule

// File: rtl/grid_peak_finder.sv
module grid_peak_finder
    import grid_pf_pkg::*;
#(
    parameter int ROWS   = 6,
    parameter int COLS   = 8,
    parameter int SUM_W  = 8,
    parameter int FRAC_W = 8,
    localparam int CELLS = ROWS * COLS,
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [SUM_W-1:0]         threshold,
    input  logic [CELLS*SUM_W-1:0]   grid_sums,
    output logic                     busy,
    output logic                     cand_valid,
    input  logic                     cand_ready,
    output logic [RW-1:0]            cand_row,
    output logic [CW-1:0]            cand_col,
    output logic signed [FRAC_W:0]   cand_drow,
    output logic signed [FRAC_W:0]   cand_dcol,
    output logic [SUM_W-1:0]         cand_peak,
    output logic                     cand_last,
    output logic                     cand_empty
);
    pf_state_e state_q, state_d;

    logic [CELLS*SUM_W-1:0] grid_q;
    logic [SUM_W-1:0]       thr_q;
    logic [RW-1:0]          row_q;
    logic [CW-1:0]          col_q;

    logic                   hold_v_q;
    logic [RW-1:0]          h_row_q;
    logic [CW-1:0]          h_col_q;
    logic signed [FRAC_W:0] h_drow_q, h_dcol_q;
    logic [SUM_W-1:0]       h_peak_q;

    logic [9*SUM_W-1:0]     win;
    logic                   hit;
    logic signed [FRAC_W:0] drow_w, dcol_w;
    logic                   last_cell;
    logic                   load_held;
    logic                   advance;

    grid_window #(.ROWS(ROWS), .COLS(COLS), .SUM_W(SUM_W), .RW(RW), .CW(CW)) u_win (
        .grid_flat (grid_q),
        .row       (row_q),
        .col       (col_q),
        .win_flat  (win)
    );

    peak_eval #(.SUM_W(SUM_W)) u_peak (
        .win_flat (win),
        .thr      (thr_q),
        .is_peak  (hit)
    );

    centroid_calc #(.SUM_W(SUM_W), .FRAC_W(FRAC_W)) u_cent (
        .win_flat (win),
        .drow     (drow_w),
        .dcol     (dcol_w)
    );

    assign last_cell = (row_q == RW'(ROWS-1)) && (col_q == CW'(COLS-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and scan controls
    always_comb begin
        state_d   = state_q;
        load_held = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (hit && hold_v_q) begin
                    state_d = ST_EMIT;
                end else begin
                    load_held = hit;
                    advance   = 1'b1;
                    if (last_cell) state_d = ST_FLUSH;
                end
            end
            ST_EMIT: begin
                if (cand_ready) begin
                    load_held = 1'b1;
                    advance   = 1'b1;
                    state_d   = last_cell ? ST_FLUSH : ST_SCAN;
                end
            end
            ST_FLUSH: begin
                if (cand_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        cand_valid = (state_q == ST_EMIT) || (state_q == ST_FLUSH);
        cand_last  = (state_q == ST_FLUSH);
        cand_empty = (state_q == ST_FLUSH) && !hold_v_q;
        cand_row   = h_row_q;
        cand_col   = h_col_q;
        cand_drow  = h_drow_q;
        cand_dcol  = h_dcol_q;
        cand_peak  = h_peak_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_q   <= '0;
            thr_q    <= '0;
            row_q    <= '0;
            col_q    <= '0;
            hold_v_q <= 1'b0;
            h_row_q  <= '0;
            h_col_q  <= '0;
            h_drow_q <= '0;
            h_dcol_q <= '0;
            h_peak_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                grid_q   <= grid_sums;
                thr_q    <= threshold;
                row_q    <= '0;
                col_q    <= '0;
                hold_v_q <= 1'b0;
            end
            if (load_held) begin
                hold_v_q <= 1'b1;
                h_row_q  <= row_q;
                h_col_q  <= col_q;
                h_drow_q <= drow_w;
                h_dcol_q <= dcol_w;
                h_peak_q <= win[WIN_CENTRE*SUM_W +: SUM_W];
            end
            if (advance) begin
                if (col_q == CW'(COLS-1)) begin
                    col_q <= '0;
                    row_q <= row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/grid_pf_checker.sv
module grid_pf_checker #(
    parameter int SUM_W  = 8,
    parameter int FRAC_W = 8,
    parameter int RW     = 3,
    parameter int CW     = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   cand_valid,
    input logic                   cand_ready,
    input logic [RW-1:0]          cand_row,
    input logic [CW-1:0]          cand_col,
    input logic signed [FRAC_W:0] cand_drow,
    input logic signed [FRAC_W:0] cand_dcol,
    input logic [SUM_W-1:0]       cand_peak,
    input logic                   cand_last,
    input logic                   cand_empty,
    input logic [SUM_W-1:0]       thr_q
);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && !cand_ready |=> cand_valid &&
        $stable({cand_row, cand_col, cand_drow, cand_dcol, cand_peak, cand_last, cand_empty}));

    // R9
    empty_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && cand_empty |-> cand_last);

    // R3
    above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && !cand_empty |-> cand_peak > thr_q);

    // R10
    final_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid && cand_ready && cand_last |=> !busy);

    // R2
    thr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(thr_q));

    // R1
    valid_in_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> busy);
endmodule

bind grid_peak_finder grid_pf_checker #(
    .SUM_W(SUM_W), .FRAC_W(FRAC_W), .RW(RW), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cand_valid (cand_valid),
    .cand_ready (cand_ready),
    .cand_row   (cand_row),
    .cand_col   (cand_col),
    .cand_drow  (cand_drow),
    .cand_dcol  (cand_dcol),
    .cand_peak  (cand_peak),
    .cand_last  (cand_last),
    .cand_empty (cand_empty),
    .thr_q      (thr_q)
);

// File: tb/grid_peak_finder_test.sv
module grid_peak_finder_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS   = 6;
    localparam int COLS   = 8;
    localparam int SUM_W  = 8;
    localparam int FRAC_W = 8;
    localparam int CELLS  = ROWS * COLS;
    localparam int RW     = 3;
    localparam int CW     = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [SUM_W-1:0]       threshold = '0;
    logic [CELLS*SUM_W-1:0] grid_sums = '0;
    logic                   busy;
    logic                   cand_valid;
    logic                   cand_ready = 1'b0;
    logic [RW-1:0]          cand_row;
    logic [CW-1:0]          cand_col;
    logic signed [FRAC_W:0] cand_drow, cand_dcol;
    logic [SUM_W-1:0]       cand_peak;
    logic                   cand_last, cand_empty;

    grid_peak_finder #(.ROWS(ROWS), .COLS(COLS), .SUM_W(SUM_W), .FRAC_W(FRAC_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .threshold(threshold),
        .grid_sums(grid_sums), .busy(busy), .cand_valid(cand_valid),
        .cand_ready(cand_ready), .cand_row(cand_row), .cand_col(cand_col),
        .cand_drow(cand_drow), .cand_dcol(cand_dcol), .cand_peak(cand_peak),
        .cand_last(cand_last), .cand_empty(cand_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int wd_cycles = 0;

    int g [ROWS][COLS];
    int thr_b;
    int e_row [CELLS];
    int e_col [CELLS];
    int e_peak[CELLS];
    int e_dr  [CELLS];
    int e_dc  [CELLS];
    int e_n;
    int busy_cyc;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cv(input int r, input int c);
        if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
        return g[r][c];
    endfunction

    function automatic bit model_peak(input int r, input int c);
        int v;
        v = g[r][c];
        if (v <= thr_b) return 0;
        if (v <= cv(r-1, c-1) || v <= cv(r-1, c) || v <= cv(r-1, c+1) || v <= cv(r, c-1)) return 0;
        if (v < cv(r, c+1) || v < cv(r+1, c-1) || v < cv(r+1, c) || v < cv(r+1, c+1)) return 0;
        return 1;
    endfunction

    task automatic build_model();
        e_n = 0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (model_peak(r, c)) begin
                    int up, dn, lf, rt, tot;
                    up = cv(r-1,c-1) + cv(r-1,c) + cv(r-1,c+1);
                    dn = cv(r+1,c-1) + cv(r+1,c) + cv(r+1,c+1);
                    lf = cv(r-1,c-1) + cv(r,c-1) + cv(r+1,c-1);
                    rt = cv(r-1,c+1) + cv(r,c+1) + cv(r+1,c+1);
                    tot = up + dn + cv(r,c-1) + cv(r,c) + cv(r,c+1);
                    e_row[e_n]  = r;
                    e_col[e_n]  = c;
                    e_peak[e_n] = g[r][c];
                    e_dr[e_n]   = ((dn - up) * (1 << FRAC_W)) / tot;
                    e_dc[e_n]   = ((rt - lf) * (1 << FRAC_W)) / tot;
                    e_n++;
                end
            end
        end
    endtask

    task automatic clear_grid();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                g[r][c] = 0;
    endtask

    task automatic run_event(input int ready_pct, input bit poke);
        int  beat;
        int  cyc;
        bit  done;
        bit  prev_stall;
        bit  rdy;
        int  s_row, s_col, s_dr, s_dc, s_pk, s_last, s_empty;
        @(negedge clk);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                grid_sums[(r*COLS+c)*SUM_W +: SUM_W] = SUM_W'(g[r][c]);
        threshold = SUM_W'(thr_b);
        start = 1'b1;
        build_model();
        @(negedge clk);
        start = 1'b0;
        beat = 0; cyc = 0; done = 0; prev_stall = 0; busy_cyc = 0;
        s_row = 0; s_col = 0; s_dr = 0; s_dc = 0; s_pk = 0; s_last = 0; s_empty = 0;
        while (!done) begin
            if (busy) busy_cyc++;
            if (poke && cyc == 2) begin
                start = 1'b1;
                grid_sums = ~grid_sums;
                threshold = '0;
            end else begin
                start = 1'b0;
            end
            if (prev_stall) begin
                // R10 stalled beat must be unchanged
                check_eq("R10", "valid held", int'(cand_valid), 1);
                check_eq("R10", "row held", int'(cand_row), s_row);
                check_eq("R10", "col held", int'(cand_col), s_col);
                check_eq("R10", "dcol held", int'(cand_dcol), s_dc);
                check_eq("R10", "drow held", int'(cand_drow), s_dr);
                check_eq("R10", "peak held", int'(cand_peak), s_pk);
                check_eq("R10", "last held", int'(cand_last), s_last);
                check_eq("R10", "empty held", int'(cand_empty), s_empty);
            end
            rdy = (int'($urandom % 100) < ready_pct);
            cand_ready = rdy;
            prev_stall = cand_valid && !rdy;
            if (cand_valid) begin
                s_row = int'(cand_row); s_col = int'(cand_col);
                s_dr = int'(cand_drow); s_dc = int'(cand_dcol);
                s_pk = int'(cand_peak); s_last = int'(cand_last); s_empty = int'(cand_empty);
                if (rdy) begin
                    if (e_n == 0) begin
                        check_eq("R9", "empty flag", int'(cand_empty), 1);
                        check_eq("R9", "last flag", int'(cand_last), 1);
                    end else if (beat < e_n) begin
                        check_eq("R5", "row", int'(cand_row), e_row[beat]);
                        check_eq("R5", "col", int'(cand_col), e_col[beat]);
                        check_eq("R7", "peak", int'(cand_peak), e_peak[beat]);
                        check_eq("R6", "drow", int'(cand_drow), e_dr[beat]);
                        check_eq("R6", "dcol", int'(cand_dcol), e_dc[beat]);
                        check_eq("R8", "last flag", int'(cand_last), (beat == e_n-1) ? 1 : 0);
                        check_eq("R8", "empty flag", int'(cand_empty), 0);
                    end else begin
                        check_eq("R8", "surplus beat index", beat, e_n - 1);
                    end
                    beat++;
                    if (cand_last) done = 1;
                end
            end
            @(negedge clk);
            cyc++;
        end
        cand_ready = 1'b0;
        start = 1'b0;
        check_eq("R10", "busy after final beat", int'(busy), 0);
        check_eq("R4", "beat count", beat, (e_n == 0) ? 1 : e_n);
    endtask

    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1", "busy in reset", int'(busy), 0);
        check_eq("R1", "valid in reset", int'(cand_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "busy after reset", int'(busy), 0);
        check_eq("R1", "valid after reset", int'(cand_valid), 0);

        // R9 / R11: empty grid, full-rate consumer
        clear_grid(); thr_b = 0;
        run_event(100, 0);
        check_eq("R11", "busy cycles", busy_cyc, CELLS + 1);

        // R6: single interior peak with uneven neighbours
        clear_grid(); thr_b = 10;
        g[2][3] = 50; g[2][4] = 20; g[1][3] = 5; g[3][2] = 12; g[3][3] = 9; g[1][2] = 3;
        run_event(100, 0);

        // R4: corner peak, neighbours outside count as zero
        clear_grid(); thr_b = 0;
        g[0][0] = 40; g[0][1] = 20; g[1][0] = 10;
        run_event(70, 0);

        // R4: 2x2 plateau gives one candidate at its top-left
        clear_grid(); thr_b = 0;
        g[3][4] = 30; g[3][5] = 30; g[4][4] = 30; g[4][5] = 30;
        run_event(100, 0);

        // R4: diagonal tie keeps only the earlier cell
        clear_grid(); thr_b = 0;
        g[1][6] = 30; g[2][5] = 30;
        run_event(100, 0);

        // R3: sum equal to threshold does not qualify
        clear_grid(); thr_b = 25;
        g[4][6] = 25;
        run_event(100, 0);
        thr_b = 24;
        run_event(100, 0);

        // R2: start with a different grid while busy is ignored
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                g[r][c] = int'($urandom % 16);
        thr_b = 6;
        run_event(50, 1);

        // random events, dense small values and full-range values
        for (int ev = 0; ev < 40; ev++) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    g[r][c] = (ev % 2 == 0) ? int'($urandom % 16) : int'($urandom % 256);
            thr_b = (ev % 2 == 0) ? int'($urandom % 12) : int'($urandom % 200);
            run_event(30 + int'($urandom % 71), (ev % 5 == 0) ? 1'b1 : 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule